// File: doc/BRIEF.md
# Double-Buffered Channel Drive Register Bank

This block is the register file that sits behind a display driver's serial front end. A host writes bytes to addressed registers: sixteen data registers hold one on/off bit per output channel, 122 channels in all, and one control register carries the pump enable, the half-level select, the reference select and a load bit. The data bits do not reach the channel outputs directly. A second bank of per-channel latches stands between them, so every channel changes state in the same cycle.

While the load bit is set, the latches follow the data registers. When the load bit is cleared, the latches hold and the outputs keep that pattern until the next load. Each channel output is a 2-bit drive code: ground, half level or full level. The half-level select is applied to the latched pattern without a new load. A busy flag marks the minimum time the load bit must stay set. This time is a parameter given in clock cycles. Data writes made while the flag is up are dropped.

Top module: `chan_out_bank`

## Requirements
- R1: Data register n (addresses 0x00 to 0x0E) holds channels 8n+1 to 8n+8. Bit 0 of the register is the lowest-numbered of those channels. The code of channel c sits at `chan_code[2c-1:2c-2]`.
- R2: Register 0x0F holds only channel 121 (bit 0) and channel 122 (bit 1). Writes to its bits 7:2 have no effect on any output.
- R3: Control register 0x10 drives `pump_en` from bit 7 and `ref_sel` from bits 1:0, one cycle after the write. The `ref_sel` codes 00, 01, 10 and 11 stand for 1.5, 1.6, 1.7 and 1.8 reference units.
- R4: While the load bit (control bit 3) is 1, the latches take the data register contents. A data write then reaches the channel codes two cycles after the write edge.
- R5: While the load bit is 0, data writes leave the channel codes unchanged.
- R6: The drive code of a channel is 00 when its latched bit is 0. It is 10 when the bit is 1 and half select (control bit 5) is 0, and 01 when the bit is 1 and half select is 1. A change of half select alone changes the codes. Code 11 never appears.
- R7: A synchronous active-high reset clears all registers: every code 00, `pump_en` 0, `ref_sel` 00, `busy` 0.
- R8: Before the first load, every channel code stays 00 whatever the data registers hold.
- R9: Writes to addresses above 0x10 change no register and no output.
- R10: A control write that sets the load bit while it was 0 raises `busy` for exactly HOLD_CYCLES cycles. Data register writes made while `busy` is 1 are ignored.
- R11: Control bits 6, 4 and 2 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (5) | Register address |
| wr_data | input | 8 | Write data |
| chan_code | output | 2*NUM_CH (244) | Per-channel drive code: 00 ground, 01 half, 10 full |
| pump_en | output | 1 | Charge pump enable |
| ref_sel | output | 2 | Reference voltage select |
| busy | output | 1 | Minimum load-hold time still running |

## Verification
A vector table writes in turn to the first data register, to a middle register, to the partial last register, to an unused address and to the control register. It probes a single channel after each write. This tells bit-to-channel mapping errors apart from address decode errors. Control patterns toggle load, half select and the test bits separately from one another. The probe then shows whether an output change comes from transparency, from the half-level encoding or from a stray field. Directed sequences cover the reset state and the gating of outputs before the first load. They also measure the exact length of the busy window and confirm that a data write inside that window is lost.

// File: rtl/chan_bank_pkg.sv
package chan_bank_pkg;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_HALF = 2'b01,
    DRV_FULL = 2'b10
  } drv_code_e;

  localparam int CTRL_PUMP_BIT = 7;
  localparam int CTRL_HALF_BIT = 5;
  localparam int CTRL_LOAD_BIT = 3;
  localparam int REG_W         = 8;

  function automatic logic [1:0] drv_encode(input logic bit_on, input logic half);
    if (!bit_on) return DRV_OFF;
    return half ? DRV_HALF : DRV_FULL;
  endfunction

endpackage

// File: rtl/chan_data_regs.sv
module chan_data_regs #(
  parameter int NUM_CH = 122,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              wr_block,
  output logic [NUM_CH-1:0] data_bits
);
  import chan_bank_pkg::*;

  localparam int NUM_REGS = (NUM_CH + REG_W - 1) / REG_W;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    localparam int LO = r * REG_W;
    localparam int W  = (NUM_CH - LO >= REG_W) ? REG_W : (NUM_CH - LO);
    logic         hit;
    logic [W-1:0] q;

    assign hit = wr_en && !wr_block && (wr_addr == ADDR_W'(r));

    always_ff @(posedge clk) begin
      if (rst)      q <= '0;
      else if (hit) q <= wr_data[W-1:0];
    end

    assign data_bits[LO +: W] = q;
  end

endmodule

// File: rtl/chan_ctrl_reg.sv
module chan_ctrl_reg #(
  parameter int ADDR_W      = 5,
  parameter int CTRL_ADDR   = 16,
  parameter int HOLD_CYCLES = 125
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              pump_en,
  output logic              half_en,
  output logic              load_en,
  output logic [1:0]        ref_sel,
  output logic              busy
);
  import chan_bank_pkg::*;

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic             ctrl_hit;
  logic             load_rise;
  logic [CNT_W-1:0] hold_cnt;

  assign ctrl_hit  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
  assign load_rise = ctrl_hit && wr_data[CTRL_LOAD_BIT] && !load_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_en <= 1'b0;
      half_en <= 1'b0;
      load_en <= 1'b0;
      ref_sel <= 2'b00;
    end else if (ctrl_hit) begin
      pump_en <= wr_data[CTRL_PUMP_BIT];
      half_en <= wr_data[CTRL_HALF_BIT];
      load_en <= wr_data[CTRL_LOAD_BIT];
      ref_sel <= wr_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 hold_cnt <= '0;
    else if (load_rise)      hold_cnt <= CNT_W'(HOLD_CYCLES);
    else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign busy = (hold_cnt != '0);

endmodule

// File: rtl/chan_latch_out.sv
module chan_latch_out #(
  parameter int NUM_CH = 122
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_en,
  input  logic                half_en,
  input  logic [NUM_CH-1:0]   data_bits,
  output logic [NUM_CH-1:0]   latch_bits,
  output logic [2*NUM_CH-1:0] chan_code
);
  import chan_bank_pkg::*;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)          latch_bits[c] <= 1'b0;
      else if (load_en) latch_bits[c] <= data_bits[c];
    end

    always_ff @(posedge clk) begin
      if (rst) chan_code[2*c +: 2] <= DRV_OFF;
      else     chan_code[2*c +: 2] <= drv_encode(latch_bits[c], half_en);
    end
  end

endmodule

// File: rtl/chan_out_bank.sv
module chan_out_bank #(
  parameter int NUM_CH      = 122,
  parameter int ADDR_W      = 5,
  parameter int HOLD_CYCLES = 125
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  output logic [2*NUM_CH-1:0] chan_code,
  output logic                pump_en,
  output logic [1:0]          ref_sel,
  output logic                busy
);
  localparam int CTRL_ADDR = (NUM_CH + 7) / 8;

  logic [NUM_CH-1:0] data_bits;
  logic [NUM_CH-1:0] latch_bits;
  logic              load_en;
  logic              half_en;

  chan_ctrl_reg #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pump_en(pump_en), .half_en(half_en), .load_en(load_en),
    .ref_sel(ref_sel), .busy(busy)
  );

  chan_data_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_block(busy), .data_bits(data_bits)
  );

  chan_latch_out #(.NUM_CH(NUM_CH)) u_latch (
    .clk(clk), .rst(rst), .load_en(load_en), .half_en(half_en),
    .data_bits(data_bits), .latch_bits(latch_bits), .chan_code(chan_code)
  );

endmodule

// File: rtl/chan_out_bank_chk.sv
module chan_out_bank_chk #(
  parameter int NUM_CH      = 122,
  parameter int ADDR_W      = 5,
  parameter int HOLD_CYCLES = 125
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [7:0]          wr_data,
  input logic [2*NUM_CH-1:0] chan_code,
  input logic                pump_en,
  input logic [1:0]          ref_sel,
  input logic                busy,
  input logic                load_en,
  input logic [NUM_CH-1:0]   data_bits,
  input logic [NUM_CH-1:0]   latch_bits
);
  localparam int CTRL_ADDR = (NUM_CH + 7) / 8;
  localparam int RUN_W     = $clog2(HOLD_CYCLES + 2);

  logic [RUN_W-1:0] busy_run;

  always_ff @(posedge clk) begin
    if (rst)       busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (chan_code == '0) && !pump_en && (ref_sel == 2'b00) && !busy);

  assert_ctrl_fields_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) |=>
      (pump_en == $past(wr_data[7])) && (ref_sel == $past(wr_data[1:0])));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(load_en) |-> $stable(latch_bits));

  assert_bad_addr_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADDR_W'(CTRL_ADDR)) |=>
      $stable(data_bits) && $stable(pump_en) && $stable(ref_sel));

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && wr_addr < ADDR_W'(CTRL_ADDR)) |=> $stable(data_bits));

  assert_busy_window_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < RUN_W'(HOLD_CYCLES)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_code
    assert_no_code11_R6: assert property (@(posedge clk) disable iff (rst)
      chan_code[2*c +: 2] != 2'b11);
  end

endmodule

bind chan_out_bank chan_out_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .chan_code(chan_code), .pump_en(pump_en), .ref_sel(ref_sel), .busy(busy),
  .load_en(load_en), .data_bits(data_bits), .latch_bits(latch_bits)
);

// File: tb/chan_out_bank_bench.sv
module chan_out_bank_bench;

  localparam int NUM_CH = 122;
  localparam int ADDR_W = 5;
  localparam int HOLD   = 20;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                wr_en = 1'b0;
  logic [ADDR_W-1:0]   wr_addr = '0;
  logic [7:0]          wr_data = '0;
  logic [2*NUM_CH-1:0] chan_code;
  logic                pump_en;
  logic [1:0]          ref_sel;
  logic                busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  chan_out_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .HOLD_CYCLES(HOLD)) u_chan_out_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chan_code(chan_code), .pump_en(pump_en), .ref_sel(ref_sel), .busy(busy)
  );

  typedef struct packed {
    logic [4:0] addr;
    logic [7:0] data;
    logic [7:0] wait_c;
    logic [7:0] probe;
    logic [1:0] exp_code;
    logic       exp_pump;
    logic [1:0] exp_ref;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t TBL [NVEC] = '{
    '{5'h10, 8'h88, 8'd25, 8'd1,   2'b10, 1'b1, 2'd0},  // R4 load rises
    '{5'h00, 8'h55, 8'd4,  8'd2,   2'b00, 1'b1, 2'd0},  // R1 bit1 clear
    '{5'h1F, 8'hFF, 8'd4,  8'd2,   2'b00, 1'b1, 2'd0},  // R9 bad address
    '{5'h01, 8'h80, 8'd4,  8'd16,  2'b10, 1'b1, 2'd0},  // R1 reg1 bit7
    '{5'h0F, 8'hFC, 8'd4,  8'd121, 2'b00, 1'b1, 2'd0},  // R2 upper bits
    '{5'h0F, 8'h02, 8'd4,  8'd122, 2'b10, 1'b1, 2'd0},  // R2 background
    '{5'h10, 8'hA0, 8'd4,  8'd1,   2'b01, 1'b1, 2'd0},  // R6 half, load off
    '{5'h00, 8'h00, 8'd4,  8'd1,   2'b01, 1'b1, 2'd0},  // R5 held
    '{5'h10, 8'h80, 8'd4,  8'd1,   2'b10, 1'b1, 2'd0},  // R6 full
    '{5'h10, 8'hD7, 8'd4,  8'd1,   2'b10, 1'b1, 2'd3},  // R11 test bits, R3
    '{5'h10, 8'h09, 8'd25, 8'd1,   2'b00, 1'b0, 2'd1}   // R3 R4 reload
  };

  function automatic logic [1:0] code_of(input int ch);
    return chan_code[2*(ch-1) +: 2];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    check("R7 codes", 32'(chan_code == '0), 1);
    check("R7 pump", pump_en, 0);
    check("R7 ref", ref_sel, 0);
    check("R7 busy", busy, 0);

    // R8 no output before first load
    wr(5'h00, 8'hFF);
    wr(5'h10, 8'h20);
    idle(4);
    check("R8 ch1", code_of(1), 2'b00);
    check("R8 all", 32'(chan_code == '0), 1);

    for (int v = 0; v < NVEC; v++) begin
      wr(TBL[v].addr, TBL[v].data);
      idle(int'(TBL[v].wait_c));
      check($sformatf("vec%0d code", v), code_of(int'(TBL[v].probe)), TBL[v].exp_code);
      check($sformatf("vec%0d pump R3", v), pump_en, TBL[v].exp_pump);
      check($sformatf("vec%0d ref R3", v), ref_sel, TBL[v].exp_ref);
    end

    // R10 busy window length
    wr(5'h10, 8'h00);
    wr(5'h10, 8'h08);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    check("R10 busy length", n, HOLD);

    // R10 data write during busy is dropped
    wr(5'h10, 8'h00);
    wr(5'h10, 8'h08);
    check("R10 busy raised", busy, 1);
    wr(5'h00, 8'hFF);
    idle(HOLD + 4);
    check("R10 dropped write", code_of(1), 2'b00);

    // R4 transparency resumes after busy
    wr(5'h00, 8'h01);
    idle(4);
    check("R4 transparent", code_of(1), 2'b10);

    // R7 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R7 reset again", 32'(chan_code == '0), 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule